// File: doc/BRIEF.md
# Windowed Watchdog with Reset-Cause Status

This block is a windowed watchdog. It counts ticks from an external timebase and expects software to service it, through a clear strobe, in the second part of each period. The block asks for a reset in two cases: the period runs out with no clear, or a clear arrives too early.

The block keeps a four-bit status word. The word holds a sticky record of why the last watchdog reset happened, two configuration-fault indicators and the live state of the clear window. The sticky cause bit is dropped by any status read or by any write to the timing register. The same status word is what a timing-register write returns.

Two board-level faults change the behaviour:
- **Missing timing resistor.** The counter switches to a fallback period length and the early-clear check is switched off.
- **Grounded configuration pin.** The watchdog is disabled altogether, so the system can come straight up into normal operation.

Top module: `wdog_window_ctrl`

## Requirements
- R1: `stat_o` bit positions are fixed: bit 3 is the reset-cause flag, bit 2 is the resistor-fault flag (a copy of `rmiss_i`), bit 1 is the disabled flag (a copy of `gnd_i`), and bit 0 is the window-open flag.
- R2: With no fault present, when `PER_TICKS` ticks pass after reset or after a restart with no clear, `rst_req_o` rises. The cause flag (bit 3) is set in the same clock cycle, and the count starts again from zero.
- R3: With no fault present, the window-open flag reads 0 for the first `PER_TICKS/2` ticks of a period and reads 1 for the remaining ticks.
- R4: A clear given while the window is open restarts the period and does not raise `rst_req_o`.
- R5: With no fault present, a clear given while the window is closed raises `rst_req_o` and sets the cause flag one clock cycle after the strobe.
- R6: A pulse on `stat_rd_i` or on `tmr_wr_i` clears the cause flag one clock cycle later. If a reset event happens in the same cycle, the flag is set instead.
- R7: While `rmiss_i` is 1, the period length is `FB_TICKS`, the window-open flag reads 1, and a clear at any point in the period restarts the period without a reset.
- R8: While `gnd_i` is 1, `rst_req_o` never rises, clears have no effect, the window-open flag reads 0, and the count is held at zero.
- R9: After `rst_n` is released, `stat_o` reads 0 and `rst_req_o` is 0 while both fault inputs are low.
- R10: Once `rst_req_o` is raised, it stays high until the next tick and falls on that tick. Clock cycles with no tick do not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase tick |
| clr_i | input | 1 | Watchdog clear strobe |
| stat_rd_i | input | 1 | Status register read strobe |
| tmr_wr_i | input | 1 | Timing register write strobe |
| rmiss_i | input | 1 | Timing resistor missing |
| gnd_i | input | 1 | Configuration pin grounded (watchdog off) |
| rst_req_o | output | 1 | Reset request, one tick interval long |
| stat_o | output | 4 | Status word {cause, resistor fault, off, window open} |

## Verification
The bench places clears exactly on both sides of the window boundary: after half the period minus one tick, and after exactly half the period. A design that has the boundary off by one either resets on a legal clear or accepts an early one.

It checks that the reset pulse outlives idle cycles and ends on the next tick. A design that times the pulse in clock cycles drops it too soon.

It puts a status read and a closed-window clear in the same cycle. A design that gives the clear-on-read priority would lose the reset cause.

Under resistor fault, the bench clears very early and then waits the fallback length. Under a grounded pin, it runs far past any period. These catch a design that keeps windowing, keeps the normal period, or still fires when it should be disabled.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // bit positions inside the status word
   localparam int unsigned ST_CAUSE = 3;
   localparam int unsigned ST_RERR  = 2;
   localparam int unsigned ST_OFF   = 1;
   localparam int unsigned ST_WIN   = 0;
   localparam int unsigned ST_W     = 4;

   typedef struct packed {
      logic cause;
      logic rerr;
      logic off;
      logic win;
   } wdog_stat_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wdog_period_cnt.sv
module wdog_period_cnt #(
   parameter int unsigned PER_TICKS = 16,
   parameter int unsigned FB_TICKS  = 10,
   parameter int unsigned CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,      // 0 = held at zero (watchdog off)
   input  logic             use_fb_i,   // fallback period selected
   input  logic             restart_i,  // a clear was taken this cycle
   output logic             expire_o,   // last tick of the period
   output logic             half_o,     // second half of the period reached
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(PER_TICKS - 1);
   localparam logic [CNT_W-1:0] NORM_HALF = CNT_W'(PER_TICKS / 2);
   localparam logic [CNT_W-1:0] FB_LAST   = CNT_W'(FB_TICKS - 1);
   localparam logic [CNT_W-1:0] FB_HALF   = CNT_W'(FB_TICKS / 2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_v;
   logic [CNT_W-1:0] half_v;
   logic             at_end;

   // period limits: one constant pair, or a selectable pair
   generate
      if (FB_TICKS == PER_TICKS) begin : g_one_period
         assign last_v = NORM_LAST;
         assign half_v = NORM_HALF;
      end else begin : g_two_period
         assign last_v = use_fb_i ? FB_LAST : NORM_LAST;
         assign half_v = use_fb_i ? FB_HALF : NORM_HALF;
      end
   endgenerate

   // >= covers a switch to the shorter period in mid count
   assign at_end   = (cnt_q >= last_v);
   assign expire_o = run_i && tick_i && at_end && !restart_i;
   assign half_o   = (cnt_q >= half_v);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || restart_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (at_end) cnt_q <= '0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= NORM_LAST || cnt_q <= FB_LAST) else $error("count out of range"); // R2

   AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0) else $error("count moved while off"); // R8

endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic trip_i,    // timeout or early clear
   input  logic ack_i,     // status read or timing write
   output logic rst_req_o,
   output logic cause_o
);

   logic req_q;
   logic cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (trip_i) begin
         req_q <= 1'b1;
      end else if (tick_i) begin
         req_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= 1'b0;
      end else if (trip_i) begin
         cause_q <= 1'b1;
      end else if (ack_i) begin
         cause_q <= 1'b0;
      end
   end

   assign rst_req_o = req_q;
   assign cause_o   = cause_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_q && !tick_i |=> req_q) else $error("request dropped without tick"); // R10

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i && !trip_i |=> !cause_q) else $error("cause not cleared"); // R6

   AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      trip_i |=> req_q && cause_q) else $error("trip lost"); // R5

endmodule

// File: rtl/wdog_window_ctrl.sv
module wdog_window_ctrl #(
   parameter int unsigned PER_TICKS = 16,
   parameter int unsigned FB_TICKS  = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       clr_i,
   input  logic       stat_rd_i,
   input  logic       tmr_wr_i,
   input  logic       rmiss_i,
   input  logic       gnd_i,
   output logic       rst_req_o,
   output logic [3:0] stat_o
);

   import wdog_pkg::*;

   localparam int unsigned MAX_T = max_u(PER_TICKS, FB_TICKS);
   localparam int unsigned CNT_W = (MAX_T > 2) ? $clog2(MAX_T) : 1;

   generate
      if (PER_TICKS < 2) begin : g_chk_per
         $error("PER_TICKS must be at least 2");
      end
      if (FB_TICKS < 2) begin : g_chk_fb
         $error("FB_TICKS must be at least 2");
      end
   endgenerate

   logic             run;
   logic             half;
   logic             win_open;
   logic             clr_ok;
   logic             clr_bad;
   logic             expire;
   logic             trip;
   logic             cause;
   logic [CNT_W-1:0] cnt;
   wdog_stat_t       st;

   assign run      = !gnd_i;
   // missing resistor: no window, clear accepted any time
   assign win_open = run && (rmiss_i || half);
   assign clr_ok   = run && clr_i && win_open;
   assign clr_bad  = run && clr_i && !win_open;

   wdog_period_cnt #(
      .PER_TICKS(PER_TICKS),
      .FB_TICKS (FB_TICKS),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .run_i    (run),
      .use_fb_i (rmiss_i),
      .restart_i(clr_ok || clr_bad),
      .expire_o (expire),
      .half_o   (half),
      .cnt_o    (cnt)
   );

   assign trip = expire || clr_bad;

   wdog_rst_gen u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .trip_i   (trip),
      .ack_i    (stat_rd_i || tmr_wr_i),
      .rst_req_o(rst_req_o),
      .cause_o  (cause)
   );

   assign st.cause = cause;
   assign st.rerr  = rmiss_i;
   assign st.off   = gnd_i;
   assign st.win   = win_open;
   assign stat_o   = st;

   AST_CAUSE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req_o) |-> stat_o[ST_CAUSE]) else $error("request without cause"); // R2

   AST_RMISS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      rmiss_i && !gnd_i |-> stat_o[ST_WIN]) else $error("window shut under fault"); // R7

   AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gnd_i && $past(gnd_i) && !$past(rst_req_o) |-> !rst_req_o) else $error("request while off"); // R8

   AST_OK_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok && !rst_req_o |=> !rst_req_o) else $error("legal clear reset"); // R4

endmodule

// File: tb/wdog_window_ctrl_tb.sv
module wdog_window_ctrl_tb;

   localparam int PER = 16;
   localparam int FB  = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       clr_i = 1'b0;
   logic       stat_rd_i = 1'b0;
   logic       tmr_wr_i = 1'b0;
   logic       rmiss_i = 1'b0;
   logic       gnd_i = 1'b0;
   logic       rst_req_o;
   logic [3:0] stat_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   wdog_window_ctrl #(.PER_TICKS(PER), .FB_TICKS(FB)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(clr_i),
      .stat_rd_i(stat_rd_i), .tmr_wr_i(tmr_wr_i), .rmiss_i(rmiss_i),
      .gnd_i(gnd_i), .rst_req_o(rst_req_o), .stat_o(stat_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_clr();
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
   endtask

   task automatic pulse_rd();
      stat_rd_i = 1'b1;
      @(negedge clk);
      stat_rd_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk(stat_o == 4'b0000, "R9 status", stat_o, 0);
      chk(rst_req_o == 1'b0, "R9 request", rst_req_o, 0);
   endtask

   task automatic t_timeout();
      do_reset();
      ticks(PER - 1);
      chk(rst_req_o == 1'b0, "R2 before end", rst_req_o, 0);
      ticks(1);
      chk(rst_req_o == 1'b1, "R2 request", rst_req_o, 1);
      chk(stat_o == 4'b1000, "R2/R1 status", stat_o, 4'b1000);
      repeat (3) @(negedge clk);
      chk(rst_req_o == 1'b1, "R10 held", rst_req_o, 1);
      ticks(1);
      chk(rst_req_o == 1'b0, "R10 drop", rst_req_o, 0);
   endtask

   task automatic t_window();
      do_reset();
      ticks(PER / 2 - 1);
      chk(stat_o[0] == 1'b0, "R3 closed", stat_o[0], 0);
      ticks(1);
      chk(stat_o[0] == 1'b1, "R3 open", stat_o[0], 1);
      ticks(PER / 2 - 1);
      chk(stat_o[0] == 1'b1, "R3 open end", stat_o[0], 1);
   endtask

   task automatic t_good_clear();
      do_reset();
      ticks(PER / 2);
      pulse_clr();
      chk(rst_req_o == 1'b0, "R4 no request", rst_req_o, 0);
      chk(stat_o[0] == 1'b0, "R4 restarted", stat_o[0], 0);
      ticks(PER - 1);
      chk(rst_req_o == 1'b0, "R4 period restarted", rst_req_o, 0);
      ticks(1);
      chk(rst_req_o == 1'b1, "R4 later timeout", rst_req_o, 1);
   endtask

   task automatic t_early_clear();
      do_reset();
      ticks(PER / 2 - 1);
      pulse_clr();
      chk(rst_req_o == 1'b1, "R5 request", rst_req_o, 1);
      chk(stat_o[3] == 1'b1, "R5 cause", stat_o[3], 1);
   endtask

   task automatic t_ack();
      do_reset();
      ticks(PER);
      chk(stat_o[3] == 1'b1, "R6 set", stat_o[3], 1);
      pulse_rd();
      chk(stat_o[3] == 1'b0, "R6 read clears", stat_o[3], 0);
      ticks(1);
      ticks(PER);
      tmr_wr_i = 1'b1;
      @(negedge clk);
      tmr_wr_i = 1'b0;
      chk(stat_o[3] == 1'b0, "R6 write clears", stat_o[3], 0);
      ticks(1);
      stat_rd_i = 1'b1;
      clr_i = 1'b1;
      @(negedge clk);
      stat_rd_i = 1'b0;
      clr_i = 1'b0;
      chk(stat_o[3] == 1'b1, "R6 set wins", stat_o[3], 1);
   endtask

   task automatic t_rmiss();
      do_reset();
      rmiss_i = 1'b1;
      @(negedge clk);
      chk(stat_o == 4'b0101, "R7/R1 status", stat_o, 4'b0101);
      ticks(1);
      pulse_clr();
      chk(rst_req_o == 1'b0, "R7 early clear ok", rst_req_o, 0);
      ticks(FB - 1);
      chk(rst_req_o == 1'b0, "R7 before fb end", rst_req_o, 0);
      ticks(1);
      chk(rst_req_o == 1'b1, "R7 fb timeout", rst_req_o, 1);
      rmiss_i = 1'b0;
   endtask

   task automatic t_off();
      do_reset();
      gnd_i = 1'b1;
      @(negedge clk);
      chk(stat_o == 4'b0010, "R8/R1 status", stat_o, 4'b0010);
      pulse_clr();
      chk(rst_req_o == 1'b0, "R8 clear ignored", rst_req_o, 0);
      ticks(3 * PER);
      chk(rst_req_o == 1'b0, "R8 no timeout", rst_req_o, 0);
      chk(stat_o == 4'b0010, "R8 status held", stat_o, 4'b0010);
      gnd_i = 1'b0;
      @(negedge clk);
      ticks(PER / 2 - 1);
      pulse_clr();
      chk(rst_req_o == 1'b1, "R8 count was held at zero", rst_req_o, 1);
   endtask

   initial begin
      fork
         begin
            @(negedge clk);
            t_reset();
            t_timeout();
            t_window();
            t_good_clear();
            t_early_clear();
            t_ack();
            t_rmiss();
            t_off();
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule